// File: doc/BRIEF.md
# Card Presence Interrupt Unit

The unit watches the raw card-detect pin of a removable memory card slot and tells a host processor whether a card is in the slot. The pin is first brought into the clock domain by a two-flop synchronizer. A debounce filter then accepts a new pin level only after it has stayed unchanged for a programmable number of clock cycles. The filtered state is shown in one control/status register. That register holds two request flags, which mirror the current card state, and two interrupt enables, which software writes.

A level-high interrupt is raised whenever a request flag and its matching enable are both set. Only one request flag is set at a time, because the flags show state and not events. After an insertion, software re-arms the unit by writing only the removal enable. After a removal it writes only the insertion enable. A build-time parameter removes the detection logic. The register then reads as all zeros, and software takes that as "detection unsupported, card always present".

Top module: `cardsense_irq`

## Requirements
- R1: The register has a fixed bit layout: bit 0 = insertion enable, bit 1 = insertion request, bit 2 = removal enable, bit 3 = removal request. Every bit above bit 3 reads as zero.
- R2: Once the filtered pin reads high (card present), bit 1 reads 1 and bit 3 reads 0. Once it reads low (no card), bit 3 reads 1 and bit 1 reads 0. Bits 1 and 3 are never both 1.
- R3: A write replaces both enables at once: bit 0 comes from write-data bit 0 and bit 2 comes from write-data bit 2. Write-data bits 1 and 3 do not change the request flags.
- R4: When there is no write, both enables keep their values.
- R5: A new pin level reaches the request flags only after the synchronized pin has held that level for DEBOUNCE_CYCLES consecutive cycles. A pulse shorter than that leaves the flags unchanged.
- R6: irq_o is high exactly when (bit 1 AND bit 0) OR (bit 3 AND bit 2) holds. It stays high for as long as that condition holds.
- R7: While reset is asserted, and after reset until the first debounce window completes, the register reads zero and irq_o is low. After that window the request flags follow the pin.
- R8: With DETECT_EN = 0 the register always reads zero and irq_o stays low, whatever is written or driven on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Write data; bits 0 and 2 are used |
| reg_rdata_o | output | DATA_W | Register read value |
| card_pin_i | input | 1 | Raw card-detect pin, high when a card is present |
| irq_o | output | 1 | Level-high interrupt request |

## Verification
The assertions check on every cycle the following rules. The filtered state changes only at the end of a full stable window, and only to the level the pin had then. The two request flags are never both set. A write loads both enables, and the enables hold when there is no write. The interrupt is never high while both enables are clear. Only the bench scenarios can show the behaviour that spans many cycles or needs a reference model. That covers rejection of a short glitch, no change partway through a window, state shown only after the first window following reset, the re-arm sequence with its level interrupt, writes to the request bits having no effect, and the disabled build reading as zero.

// File: rtl/cardsense_pkg.sv
package cardsense_pkg;
  // Register field positions: software decodes these, so they are fixed.
  localparam int unsigned INS_EN_BIT  = 0;
  localparam int unsigned INS_REQ_BIT = 1;
  localparam int unsigned REM_EN_BIT  = 2;
  localparam int unsigned REM_REQ_BIT = 3;
  localparam int unsigned FIELD_BITS  = 4;

  typedef struct packed {
    logic rem_en;
    logic ins_en;
  } arm_t;
endpackage

// File: rtl/cardsense_sync.sv
// Multi-stage flop chain; resets to zero asynchronously.
module cardsense_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end else begin : g_single
      assign chain_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cardsense_debounce.sv
// Accepts a new level after it has been stable for STABLE_CYCLES cycles.
module cardsense_debounce #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic valid_o,
  output logic state_o
);
  localparam int unsigned CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic             cand_q, cand_d;
  logic             state_q, state_d;
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pending;
  logic             moved;
  logic             at_last;

  assign pending = !valid_q || (cand_q != state_q);
  assign moved   = (level_i != cand_q);
  assign at_last = (cnt_q == LAST);

  always_comb begin
    cand_d  = cand_q;
    state_d = state_q;
    valid_d = valid_q;
    cnt_d   = cnt_q;
    if (moved) begin
      cand_d = level_i;
      cnt_d  = '0;
    end else if (pending) begin
      if (at_last) begin
        state_d = cand_q;
        valid_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= 1'b0;
      state_q <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cand_q  <= cand_d;
      state_q <= state_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid_o = valid_q;
  assign state_o = state_q;

  // R5: the filtered state moves only when a full window has elapsed
  p_commit_after_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> ($past(cnt_q) == LAST));

  // R5: the committed value is the level held by the input at that point
  p_commit_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> (state_q == $past(level_i)));
endmodule

// File: rtl/cardsense_regs.sv
// Enable flags, request view and interrupt combination.
module cardsense_regs
  import cardsense_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              valid_i,
  input  logic              present_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  arm_t arm_q, arm_d;
  logic ins_req;
  logic rem_req;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[DATA_W-1:FIELD_BITS], wdata_i[INS_REQ_BIT], wdata_i[REM_REQ_BIT]};

  always_comb begin
    arm_d = arm_q;
    if (wr_i) begin
      arm_d.ins_en = wdata_i[INS_EN_BIT];
      arm_d.rem_en = wdata_i[REM_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= arm_d;
  end

  assign ins_req = valid_i &&  present_i;
  assign rem_req = valid_i && !present_i;

  always_comb begin
    rdata_o              = '0;
    rdata_o[INS_EN_BIT]  = arm_q.ins_en;
    rdata_o[INS_REQ_BIT] = ins_req;
    rdata_o[REM_EN_BIT]  = arm_q.rem_en;
    rdata_o[REM_REQ_BIT] = rem_req;
  end

  assign irq_o = (ins_req && arm_q.ins_en) || (rem_req && arm_q.rem_en);

  // R3: a write loads both enables from their data bits
  p_enable_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o[INS_EN_BIT] == $past(wdata_i[INS_EN_BIT])) &&
             (rdata_o[REM_EN_BIT] == $past(wdata_i[REM_EN_BIT])));

  // R4: enables hold without a write
  p_enable_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(arm_q));

  // R6: no interrupt while both enables are clear
  p_irq_needs_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (arm_q.ins_en || arm_q.rem_en));
endmodule

// File: rtl/cardsense_irq.sv
module cardsense_irq
  import cardsense_pkg::*;
#(
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter bit          DETECT_EN       = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              card_pin_i,
  output logic              irq_o
);
  generate
    if (DETECT_EN) begin : g_detect
      logic rst_n_int;
      logic pin_sync;
      logic deb_valid;
      logic deb_state;

      // Reset: asserted asynchronously, released on a clock edge
      cardsense_sync #(.STAGES(2)) u_rst_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (1'b1),
        .q_o   (rst_n_int)
      );

      cardsense_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk_i (clk_i),
        .rst_ni(rst_n_int),
        .d_i   (card_pin_i),
        .q_o   (pin_sync)
      );

      cardsense_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
        .clk_i  (clk_i),
        .rst_ni (rst_n_int),
        .level_i(pin_sync),
        .valid_o(deb_valid),
        .state_o(deb_state)
      );

      cardsense_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_n_int),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .valid_i  (deb_valid),
        .present_i(deb_state),
        .rdata_o  (reg_rdata_o),
        .irq_o    (irq_o)
      );

      // R2: the two request flags are never set together
      p_req_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
        !(reg_rdata_o[INS_REQ_BIT] && reg_rdata_o[REM_REQ_BIT]));
    end else begin : g_absent
      logic unused_in;
      assign unused_in   = ^{clk_i, rst_ni, reg_wr_i, reg_wdata_i, card_pin_i};
      assign reg_rdata_o = '0;
      assign irq_o       = 1'b0;
    end
  endgenerate
endmodule

// File: tb/sim_cardsense_irq.sv
module sim_cardsense_irq;
  localparam int DB = 8;
  localparam int SETTLE = DB + 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        pin = 1'b1;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        irq;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always #4 clk = ~clk;

  cardsense_irq #(.DATA_W(32), .DEBOUNCE_CYCLES(DB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd0), .card_pin_i(pin), .irq_o(irq0));

  cardsense_irq #(.DATA_W(32), .DEBOUNCE_CYCLES(DB), .DETECT_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd1), .card_pin_i(pin), .irq_o(irq1));

  // Monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (rd0 !== it.rd || irq0 !== it.irq) begin
          errors++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", it.tag, rd0, irq0, it.rd, it.irq);
        end
        checks++;
        if (rd1 !== 32'h0 || irq1 !== 1'b0) begin
          errors++;
          $display("FAIL R8 (%s): rdata=%h irq=%b expected rdata=%h irq=%b", it.tag, rd1, irq1, 32'h0, 1'b0);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] rd, input logic irq);
    item_t it;
    it.tag = tag; it.rd = rd; it.irq = irq;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(posedge clk); #1 wr = 1'b1; wdata = d;
    @(posedge clk); #1 wr = 1'b0; wdata = '0;
  endtask

  task automatic drive_pin(input logic v, input int hold);
    @(posedge clk); #1 pin = v;
    cyc(hold);
  endtask

  initial begin
    #1;
    chk("R7 in reset", 32'h0, 1'b0);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R7 before first window", 32'h0, 1'b0);
    cyc(SETTLE);
    chk("R7/R2 present after window", 32'h2, 1'b0);

    write_reg(32'h1);
    chk("R3/R6 insert enable", 32'h3, 1'b1);
    cyc(5);
    chk("R6/R4 level held", 32'h3, 1'b1);

    write_reg(32'h4);
    chk("R3 re-arm remove", 32'h6, 1'b0);

    write_reg(32'hA);
    chk("R3 request bits ignored", 32'h2, 1'b0);

    write_reg(32'h4);
    drive_pin(1'b0, SETTLE);
    chk("R2/R6 removal", 32'hC, 1'b1);

    drive_pin(1'b1, DB / 2);
    drive_pin(1'b0, SETTLE);
    chk("R5 glitch rejected", 32'hC, 1'b1);

    drive_pin(1'b1, DB - 2);
    chk("R5 mid-window unchanged", 32'hC, 1'b1);
    cyc(SETTLE);
    chk("R5/R2 insertion accepted", 32'h6, 1'b0);

    write_reg(32'h5);
    chk("R6 both enables", 32'h7, 1'b1);
    write_reg(32'hFFFF_FFF5);
    chk("R1 upper bits zero", 32'h7, 1'b1);
    write_reg(32'h0);
    chk("R1/R3 enables cleared", 32'h2, 1'b0);

    @(posedge clk); #1 rst_n = 1'b0;
    cyc(1);
    chk("R7 reset mid-run", 32'h0, 1'b0);
    rst_n = 1'b1;
    cyc(SETTLE + 2);
    chk("R7 state after second reset", 32'h2, 1'b0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule